// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows a processor core through its clock-control power states. It watches the stop-clock request, the halt-instruction strobe, the deep-sleep pin, the bus-clock-present flag, the core-voltage-reduced flag, the snoop handshake, a bus of halt-break events and a synchronous system reset. From these it keeps the current power state as a one-hot code. It also keeps a remembered halt flag, a snoop-service enable and a core clock enable.

Entry into Auto Halt or Quick Start is a two-step move. The trigger is first latched as a pending request. The state changes only when the acknowledge bus cycle reports complete. When the stop-clock request is released in Quick Start, the halt flag picks the destination: Normal or Auto Halt. A return register records which state a snoop interrupted, so that finishing the snoop resumes that state. Clock gating, voltage regulation, bus cycles and snoop work are handled elsewhere. They reach this block only as handshake inputs.

Top module: `lps_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), the state is Normal, `halt_flag` is 0, `core_clk_en` is 1 and `snoop_en` is 0.
- R2: In Normal, a `halt_insn` pulse latches a pending Auto Halt entry. The state stays Normal until a cycle with `ack_done` high. That cycle moves the state to Auto Halt and sets `halt_flag`.
- R3: In Normal or Auto Halt, `stpclk_req` high latches a pending Quick Start entry. It takes effect only on a later `ack_done`. In Normal, it wins over a simultaneous `halt_insn`.
- R4: In Auto Halt, any bit of `brk_evt` high returns the state to Normal and clears `halt_flag`.
- R5: In Quick Start, `stpclk_req` low moves the state to Auto Halt if `halt_flag` is 1, and to Normal if it is 0.
- R6: In Quick Start, `bclk_ok` low or `dpslp` high moves the state to Deep Sleep. Deep Sleep goes back to Quick Start only when `bclk_ok` is 1 and `dpslp` is 0.
- R7: In Deep Sleep, `vcore_low` high moves the state to Deeper Sleep. In Deeper Sleep, `vcore_low` low moves the state back to Deep Sleep.
- R8: `snoop_req` in Quick Start or Auto Halt moves the state to Snoop, where `snoop_en` is 1. The state stays there until `snoop_done`, which returns it to the state it came from.
- R9: `sys_reset` in Quick Start clears `halt_flag`, and the state stays Quick Start while `stpclk_req` is held. A later release then goes to Normal.
- R10: In Quick Start, `brk_evt` and `halt_insn` have no effect on the state or on `halt_flag`.
- R11: `sys_reset` in any state other than Quick Start forces Normal, clears `halt_flag` and drops any pending entry. A later `ack_done` then has no effect.
- R12: `state_oh` bit 0 means Normal, bit 1 Auto Halt, bit 2 Quick Start, bit 3 Snoop, bit 4 Deep Sleep and bit 5 Deeper Sleep. Exactly one bit is set. `core_clk_en` is 1 only in Normal, and `halt_flag` is never 1 in Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_reset | input | 1 | Synchronous system reset request |
| stpclk_req | input | 1 | Stop-clock request |
| halt_insn | input | 1 | Halt instruction executed (strobe) |
| ack_done | input | 1 | Acknowledge bus cycle complete |
| dpslp | input | 1 | Deep-sleep pin, active high |
| bclk_ok | input | 1 | Bus clock is running |
| vcore_low | input | 1 | Core voltage has been reduced |
| snoop_req | input | 1 | Snoop request |
| snoop_done | input | 1 | Snoop serviced |
| brk_evt | input | NUM_BRK | Halt-break event lines |
| state_oh | output | 6 | One-hot power state |
| halt_flag | output | 1 | Remembered halt state |
| snoop_en | output | 1 | Snoop may be serviced |
| core_clk_en | output | 1 | Core clock enable |

## Verification
The assertions assume that the inputs change only between clock edges. They also assume that `ack_done` arrives only after a request has been latched, and that `snoop_done` is raised only while a snoop is in service. The directed stimulus meets these assumptions: it drives every input on the falling edge, holds each strobe for exactly one cycle, and raises `ack_done` or `snoop_done` only after the state or the pending entry that it answers has been established. Holding and priority cases assert competing inputs in the same cycle, and the checks confirm which input wins.

// File: rtl/lps_pkg.sv
package lps_pkg;
    localparam int ST_W = 6;

    localparam int IDX_NORMAL = 0;
    localparam int IDX_AHALT  = 1;
    localparam int IDX_QSTART = 2;
    localparam int IDX_SNOOP  = 3;
    localparam int IDX_DEEP   = 4;
    localparam int IDX_DEEPER = 5;

    typedef enum logic [ST_W-1:0] {
        ST_NORMAL = ST_W'(1) << IDX_NORMAL,
        ST_AHALT  = ST_W'(1) << IDX_AHALT,
        ST_QSTART = ST_W'(1) << IDX_QSTART,
        ST_SNOOP  = ST_W'(1) << IDX_SNOOP,
        ST_DEEP   = ST_W'(1) << IDX_DEEP,
        ST_DEEPER = ST_W'(1) << IDX_DEEPER
    } lps_state_e;

    typedef enum logic {
        TGT_QSTART = 1'b0,
        TGT_AHALT  = 1'b1
    } lps_tgt_e;

    typedef struct packed {
        logic     valid;
        lps_tgt_e tgt;
    } lps_pend_t;

    typedef struct packed {
        lps_state_e state;
        logic       halt;
        lps_state_e ret;
    } lps_core_t;
endpackage

// File: rtl/lps_brk_merge.sv
module lps_brk_merge #(
    parameter int NUM_BRK = 10
) (
    input  logic [NUM_BRK-1:0] brk_evt,
    output logic               brk_any
);
    logic [NUM_BRK:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < NUM_BRK; i++) begin : g_or
        assign chain[i+1] = chain[i] | brk_evt[i];
    end
    assign brk_any = chain[NUM_BRK];
endmodule

// File: rtl/lps_entry_gate.sv
module lps_entry_gate
    import lps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_qs,
    input  logic req_ah,
    input  logic accept,
    input  logic cancel,
    input  logic ack_done,
    output logic fire_qs,
    output logic fire_ah
);
    lps_pend_t pend_d, pend_q;
    logic      fire;

    assign fire    = pend_q.valid & ack_done & accept & ~cancel;
    assign fire_qs = fire & (pend_q.tgt == TGT_QSTART);
    assign fire_ah = fire & (pend_q.tgt == TGT_AHALT);

    always_comb begin
        pend_d = pend_q;
        if (cancel) begin
            pend_d.valid = 1'b0;
        end else if (pend_q.valid) begin
            if (fire) pend_d.valid = 1'b0;
        end else if (req_qs) begin
            pend_d.valid = 1'b1;
            pend_d.tgt   = TGT_QSTART;
        end else if (req_ah) begin
            pend_d.valid = 1'b1;
            pend_d.tgt   = TGT_AHALT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '{valid: 1'b0, tgt: TGT_QSTART};
        else        pend_q <= pend_d;
    end

    a_r3_no_fire_without_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_qs || fire_ah) |-> $past(req_qs || req_ah || pend_q.valid));
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
    import lps_pkg::*;
#(
    parameter int NUM_BRK = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sys_reset,
    input  logic               stpclk_req,
    input  logic               halt_insn,
    input  logic               ack_done,
    input  logic               dpslp,
    input  logic               bclk_ok,
    input  logic               vcore_low,
    input  logic               snoop_req,
    input  logic               snoop_done,
    input  logic [NUM_BRK-1:0] brk_evt,
    output logic [ST_W-1:0]    state_oh,
    output logic               halt_flag,
    output logic               snoop_en,
    output logic               core_clk_en
);
    lps_core_t core_d, core_q;
    logic brk_any, fire_qs, fire_ah;
    logic in_normal, in_ahalt, in_qstart;
    logic req_qs, req_ah, accept, cancel;

    lps_brk_merge #(.NUM_BRK(NUM_BRK)) u_brk (
        .brk_evt (brk_evt),
        .brk_any (brk_any)
    );

    assign in_normal = (core_q.state == ST_NORMAL);
    assign in_ahalt  = (core_q.state == ST_AHALT);
    assign in_qstart = (core_q.state == ST_QSTART);

    assign accept = in_normal | in_ahalt;
    assign req_qs = stpclk_req & accept;
    assign req_ah = halt_insn & in_normal;
    assign cancel = (sys_reset & ~in_qstart) | (in_ahalt & brk_any);

    lps_entry_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_qs   (req_qs),
        .req_ah   (req_ah),
        .accept   (accept),
        .cancel   (cancel),
        .ack_done (ack_done),
        .fire_qs  (fire_qs),
        .fire_ah  (fire_ah)
    );

    always_comb begin
        core_d = core_q;
        if (sys_reset && !in_qstart) begin
            core_d.state = ST_NORMAL;
            core_d.halt  = 1'b0;
        end else begin
            unique case (core_q.state)
                ST_NORMAL: begin
                    if (fire_qs) begin
                        core_d.state = ST_QSTART;
                    end else if (fire_ah) begin
                        core_d.state = ST_AHALT;
                        core_d.halt  = 1'b1;
                    end
                end
                ST_AHALT: begin
                    if (brk_any) begin
                        core_d.state = ST_NORMAL;
                        core_d.halt  = 1'b0;
                    end else if (snoop_req) begin
                        core_d.state = ST_SNOOP;
                        core_d.ret   = ST_AHALT;
                    end else if (fire_qs) begin
                        core_d.state = ST_QSTART;
                    end
                end
                ST_QSTART: begin
                    if (sys_reset) core_d.halt = 1'b0;
                    if (!bclk_ok || dpslp) begin
                        core_d.state = ST_DEEP;
                    end else if (snoop_req) begin
                        core_d.state = ST_SNOOP;
                        core_d.ret   = ST_QSTART;
                    end else if (!stpclk_req) begin
                        core_d.state = core_d.halt ? ST_AHALT : ST_NORMAL;
                    end
                end
                ST_SNOOP: begin
                    if (snoop_done) core_d.state = core_q.ret;
                end
                ST_DEEP: begin
                    if (bclk_ok && !dpslp)  core_d.state = ST_QSTART;
                    else if (vcore_low)     core_d.state = ST_DEEPER;
                end
                ST_DEEPER: begin
                    if (!vcore_low) core_d.state = ST_DEEP;
                end
                default: begin
                    core_d.state = ST_NORMAL;
                    core_d.halt  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '{state: ST_NORMAL, halt: 1'b0, ret: ST_QSTART};
        else        core_q <= core_d;
    end

    assign state_oh    = core_q.state;
    assign halt_flag   = core_q.halt;
    assign snoop_en    = (core_q.state == ST_SNOOP);
    assign core_clk_en = in_normal;

    a_r12_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1);

    a_r12_normal_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh[IDX_NORMAL] |-> !halt_flag);

    a_r3_qs_entry_acked: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state_oh[IDX_QSTART]) && ($past(state_oh[IDX_NORMAL]) || $past(state_oh[IDX_AHALT])))
            |-> $past(ack_done));

    a_r2_ah_entry_acked: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state_oh[IDX_AHALT]) && $past(state_oh[IDX_NORMAL])) |-> ($past(ack_done) && halt_flag));

    a_r4_break_exits_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[IDX_AHALT] && brk_any) |=> (state_oh[IDX_NORMAL] && !halt_flag));

    a_r10_qs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[IDX_QSTART] && stpclk_req && bclk_ok && !dpslp && !snoop_req) |=> state_oh[IDX_QSTART]);

    a_r8_snoop_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[IDX_SNOOP] && snoop_done && !sys_reset) |=> (state_oh[IDX_QSTART] || state_oh[IDX_AHALT]));

    a_r7_deeper_from_deep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_oh[IDX_DEEPER]) |-> $past(state_oh[IDX_DEEP]));
endmodule

// File: tb/lps_ctrl_tb.sv
module lps_ctrl_tb;
    localparam int NB = 10;
    localparam logic [5:0] S_N = 6'b000001, S_AH = 6'b000010, S_QS = 6'b000100,
                           S_SN = 6'b001000, S_DS = 6'b010000, S_DR = 6'b100000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sys_reset = 0, stpclk_req = 0, halt_insn = 0, ack_done = 0, dpslp = 0;
    logic bclk_ok = 1, vcore_low = 0, snoop_req = 0, snoop_done = 0;
    logic [NB-1:0] brk_evt = '0;
    logic [5:0] state_oh;
    logic halt_flag, snoop_en, core_clk_en;
    int nchk = 0, nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lps_ctrl #(.NUM_BRK(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .stpclk_req(stpclk_req),
        .halt_insn(halt_insn), .ack_done(ack_done), .dpslp(dpslp), .bclk_ok(bclk_ok),
        .vcore_low(vcore_low), .snoop_req(snoop_req), .snoop_done(snoop_done),
        .brk_evt(brk_evt), .state_oh(state_oh), .halt_flag(halt_flag),
        .snoop_en(snoop_en), .core_clk_en(core_clk_en)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic enter_qs();
        stpclk_req = 1; tick();
        ack_done = 1; tick(); ack_done = 0;
    endtask

    task automatic enter_ah();
        halt_insn = 1; tick(); halt_insn = 0;
        ack_done = 1; tick(); ack_done = 0;
    endtask

    task automatic t_reset();
        chk("R1 state", state_oh, S_N);
        chk("R1 halt", halt_flag, 0);
        chk("R1 clk_en", core_clk_en, 1);
        chk("R1 snoop_en", snoop_en, 0);
    endtask

    task automatic t_halt_entry();
        halt_insn = 1; tick(); halt_insn = 0;
        chk("R2 waits for ack", state_oh, S_N);
        tick();
        chk("R2 still waiting", state_oh, S_N);
        ack_done = 1; tick(); ack_done = 0;
        chk("R2 auto halt", state_oh, S_AH);
        chk("R2 halt flag", halt_flag, 1);
        chk("R12 clk_en off", core_clk_en, 0);
    endtask

    task automatic t_break();
        brk_evt[7] = 1; tick(); brk_evt = '0;
        chk("R4 back to normal", state_oh, S_N);
        chk("R4 flag clear", halt_flag, 0);
        enter_ah();
        brk_evt[0] = 1; tick(); brk_evt = '0;
        chk("R4 bit0 break", state_oh, S_N);
    endtask

    task automatic t_qs_normal();
        stpclk_req = 1; halt_insn = 1; tick(); halt_insn = 0;
        chk("R3 pending", state_oh, S_N);
        ack_done = 1; tick(); ack_done = 0;
        chk("R3 quick start wins", state_oh, S_QS);
        chk("R3 flag clear", halt_flag, 0);
        stpclk_req = 0; tick();
        chk("R5 release to normal", state_oh, S_N);
    endtask

    task automatic t_qs_from_ah();
        enter_ah();
        enter_qs();
        chk("R3 qs from ah", state_oh, S_QS);
        chk("R3 flag kept", halt_flag, 1);
        brk_evt = '1; halt_insn = 1; tick(); brk_evt = '0; halt_insn = 0;
        chk("R10 ignores break", state_oh, S_QS);
        chk("R10 flag kept", halt_flag, 1);
        snoop_req = 1; tick(); snoop_req = 0;
        chk("R8 snoop", state_oh, S_SN);
        chk("R8 snoop_en", snoop_en, 1);
        tick();
        chk("R8 snoop held", state_oh, S_SN);
        snoop_done = 1; tick(); snoop_done = 0;
        chk("R8 back to qs", state_oh, S_QS);
        stpclk_req = 0; tick();
        chk("R5 release to ah", state_oh, S_AH);
        snoop_req = 1; tick(); snoop_req = 0;
        chk("R8 snoop from ah", state_oh, S_SN);
        snoop_done = 1; tick(); snoop_done = 0;
        chk("R8 back to ah", state_oh, S_AH);
        brk_evt[3] = 1; tick(); brk_evt = '0;
        chk("R4 exit", state_oh, S_N);
    endtask

    task automatic t_deep();
        enter_qs();
        dpslp = 1; tick();
        chk("R6 deep via pin", state_oh, S_DS);
        vcore_low = 1; tick();
        chk("R7 deeper", state_oh, S_DR);
        tick();
        chk("R7 deeper held", state_oh, S_DR);
        vcore_low = 0; tick();
        chk("R7 back to deep", state_oh, S_DS);
        dpslp = 0; tick();
        chk("R6 wake", state_oh, S_QS);
        bclk_ok = 0; tick();
        chk("R6 deep via clock stop", state_oh, S_DS);
        bclk_ok = 1; tick();
        chk("R6 wake on clock", state_oh, S_QS);
        stpclk_req = 0; tick();
        chk("R5 normal", state_oh, S_N);
    endtask

    task automatic t_qs_reset();
        enter_ah();
        enter_qs();
        sys_reset = 1; tick(); sys_reset = 0;
        chk("R9 stays qs", state_oh, S_QS);
        chk("R9 flag cleared", halt_flag, 0);
        stpclk_req = 0; tick();
        chk("R9 release to normal", state_oh, S_N);
    endtask

    task automatic t_reset_outside();
        stpclk_req = 1; tick(); stpclk_req = 0;
        sys_reset = 1; tick(); sys_reset = 0;
        ack_done = 1; tick(); ack_done = 0;
        chk("R11 pending dropped", state_oh, S_N);
        enter_ah();
        sys_reset = 1; tick(); sys_reset = 0;
        chk("R11 ah to normal", state_oh, S_N);
        chk("R11 flag clear", halt_flag, 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_halt_entry();
        t_break();
        t_qs_normal();
        t_qs_from_ah();
        t_deep();
        t_qs_reset();
        t_reset_outside();
        done = 1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end
endmodule